// File: doc/BRIEF.md
# Slave-Serial FPGA Configuration Master

This block loads a configuration image into a target FPGA over a slave-serial link. A start pulse and a byte count begin a load. The block first pulls the target's active-low program pin low for a timed interval and then releases it. It waits, within a bounded number of polls, for the target's init pin to go high. It then takes image bytes from an upstream source through a valid/ready handshake and shifts each one onto the data pin, most significant bit first, with one configuration clock pulse per bit. Once the requested number of bytes has been sent, it keeps pulsing the clock with the data pin low until the target raises its done pin. This wait is also bounded.

The init and done pins each pass through a two-flop synchronizer. The program-low interval and the clock half-period are parameters counted in system clocks. When a load ends, exactly one of three sticky flags is raised: success, init timeout or done timeout. The flag holds until the next start. Upstream can set a byte-error input while a byte is requested. This ends the data phase early, and the block goes straight to the trailing clocks.

The state machine has eight states. IDLE waits for a start, and start moves it to PROG. PROG holds the program pin low. Timer expiry moves it to WAIT_INIT. WAIT_INIT polls init. Init high moves it to FETCH, or to TRAIL_LO when the count is zero. Poll exhaustion sets the init timeout and returns to IDLE. FETCH requests a byte. A handshake moves it to BIT_LO, and a byte error moves it to TRAIL_LO. BIT_LO presents the data bit with the clock low, and timer expiry moves it to BIT_HI. BIT_HI holds the clock high. On timer expiry it goes back to BIT_LO for the next bit, to FETCH for the next byte, or to TRAIL_LO after the last byte. TRAIL_LO keeps the clock low. On expiry it goes to IDLE with success if done is seen, to IDLE with the done timeout if the pulse limit has been reached, and otherwise to TRAIL_HI. TRAIL_HI drives a data-less clock pulse and returns to TRAIL_LO.

Top module: `sscfg_master`

## Requirements
- R1: After reset, prog_n_o is high, cclk_o, din_o, busy_o and byte_ready_o are low, and ok_o, err_init_o and err_done_o are low.
- R2: A start_i pulse while idle drives prog_n_o low for exactly PROG_HOLD system clocks, with cclk_o and din_o low for that whole interval, and busy_o high from the next cycle on.
- R3: After prog_n_o is released, no clock pulse is issued until the synchronized init_i has been seen high. If it stays low for POLL_LIMIT consecutive polls, one per system clock, err_init_o is set, busy_o drops and no clock pulse is issued.
- R4: Each byte is shifted MSB first (bit 7 on the first clock pulse of the byte). din_o is set while cclk_o is low and stays stable while cclk_o is high.
- R5: Every high phase of cclk_o lasts exactly HALF_PER system clocks, and every low phase between pulses lasts at least HALF_PER.
- R6: byte_ready_o is high only while a byte is being requested, with cclk_o low. Exactly len_i bytes are accepted through the valid/ready handshake, and a length of zero accepts none.
- R7: After the data bytes, the block issues clock pulses with din_o low until the synchronized done_i is seen high, then sets ok_o and returns to idle.
- R8: If done_i is not seen after DONE_LIMIT trailing clock pulses, err_done_o is set, ok_o stays low and busy_o drops.
- R9: If byte_err_i is high while byte_ready_o is high, no more bytes are accepted, and the block continues with the trailing clock phase.
- R10: A start_i pulse while busy_o is high is ignored: prog_n_o stays as it is and the load in progress completes unchanged.
- R11: The result flags are mutually exclusive, hold their value while idle, and are cleared by the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request to begin a load |
| len_i | input | LEN_W | Number of image bytes, sampled with start_i |
| byte_data_i | input | DATA_W | Image byte from upstream |
| byte_valid_i | input | 1 | Upstream byte is valid |
| byte_err_i | input | 1 | Upstream cannot deliver; ends the data phase |
| byte_ready_o | output | 1 | Block requests a byte |
| prog_n_o | output | 1 | Active-low program pin to target |
| cclk_o | output | 1 | Configuration clock to target |
| din_o | output | 1 | Configuration data to target |
| init_i | input | 1 | Target ready-for-data pin (asynchronous) |
| done_i | input | 1 | Target configuration-complete pin (asynchronous) |
| busy_o | output | 1 | A load is in progress |
| ok_o | output | 1 | Last load finished with done seen |
| err_init_o | output | 1 | Last load timed out waiting for init |
| err_done_o | output | 1 | Last load timed out waiting for done |

## Verification
Some properties are checked on every cycle. The program pin is never low while the clock or data pin is active. The data pin does not move while the clock is high. A byte request never overlaps a clock pulse. The result flags never overlap. A start seen while busy with the program pin released never pulls that pin low. The shifter is never asked to load and shift in the same cycle. Other behaviour can only be shown by the directed scenarios, which model the target's init and done pins. These cover the exact program-low length, MSB-first byte order, the exact number of bytes consumed and of trailing pulses, the two timeout limits, the early end on a byte error, and the clearing of flags on a new start.

// File: rtl/sscfg_pkg.sv
package sscfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_WAIT_INIT,
        ST_FETCH,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_TRAIL_LO,
        ST_TRAIL_HI
    } cfg_state_t;

endpackage

// File: rtl/sscfg_sync.sv
module sscfg_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_i[g];
                stab_q <= meta_q;
            end
        end
        assign sync_o[g] = stab_q;
    end

endmodule

// File: rtl/sscfg_timer.sv
module sscfg_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sscfg_shreg.sv
module sscfg_shreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              msb_o,
    output logic              last_o
);

    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic [DATA_W-1:0] sh_q;
    logic [IW-1:0]     idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load_i) begin
            sh_q  <= data_i;
            idx_q <= '0;
        end else if (shift_i) begin
            sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
            idx_q <= idx_q + 1'b1;
        end
    end

    assign msb_o  = sh_q[DATA_W-1];
    assign last_o = (idx_q == IW'(DATA_W - 1));

    AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && shift_i)); // R4

endmodule

// File: rtl/sscfg_master.sv
module sscfg_master
    import sscfg_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int LEN_W      = 24,
    parameter int PROG_HOLD  = 1200,
    parameter int HALF_PER   = 3,
    parameter int POLL_LIMIT = 100000,
    parameter int DONE_LIMIT = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [DATA_W-1:0] byte_data_i,
    input  logic              byte_valid_i,
    input  logic              byte_err_i,
    output logic              byte_ready_o,
    output logic              prog_n_o,
    output logic              cclk_o,
    output logic              din_o,
    input  logic              init_i,
    input  logic              done_i,
    output logic              busy_o,
    output logic              ok_o,
    output logic              err_init_o,
    output logic              err_done_o
);

    localparam int TMAX = (PROG_HOLD > HALF_PER) ? PROG_HOLD : HALF_PER;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int PW   = $clog2(POLL_LIMIT + 1);
    localparam int DW   = $clog2(DONE_LIMIT + 1);
    localparam logic [TW-1:0] HOLD_LD = TW'(PROG_HOLD - 1);
    localparam logic [TW-1:0] HALF_LD = TW'(HALF_PER - 1);

    cfg_state_t state_q, state_d;

    logic             init_s, done_s;
    logic             tmr_load, tmr_zero;
    logic [TW-1:0]    tmr_val;
    logic             sh_load, sh_shift, sh_msb, sh_last;
    logic [LEN_W-1:0] left_q;
    logic             len_load, left_dec;
    logic [PW-1:0]    poll_q;
    logic             poll_clr, poll_inc;
    logic [DW-1:0]    pulse_q;
    logic             pulse_clr, pulse_inc;
    logic             clr_flags, set_ok, set_ei, set_ed;

    sscfg_sync #(.WIDTH(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({done_i, init_i}),
        .sync_o  ({done_s, init_s})
    );

    sscfg_timer #(.W(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    sscfg_shreg #(.DATA_W(DATA_W)) u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sh_load),
        .shift_i (sh_shift),
        .data_i  (byte_data_i),
        .msb_o   (sh_msb),
        .last_o  (sh_last)
    );

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            left_q     <= '0;
            poll_q     <= '0;
            pulse_q    <= '0;
            ok_o       <= 1'b0;
            err_init_o <= 1'b0;
            err_done_o <= 1'b0;
        end else begin
            state_q <= state_d;
            if (len_load)      left_q <= len_i;
            else if (left_dec) left_q <= left_q - 1'b1;
            if (poll_clr)      poll_q <= '0;
            else if (poll_inc) poll_q <= poll_q + 1'b1;
            if (pulse_clr)      pulse_q <= '0;
            else if (pulse_inc) pulse_q <= pulse_q + 1'b1;
            if (clr_flags) begin
                ok_o       <= 1'b0;
                err_init_o <= 1'b0;
                err_done_o <= 1'b0;
            end else begin
                if (set_ok) ok_o       <= 1'b1;
                if (set_ei) err_init_o <= 1'b1;
                if (set_ed) err_done_o <= 1'b1;
            end
        end
    end

    // next state and control strobes
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = HALF_LD;
        sh_load   = 1'b0;
        sh_shift  = 1'b0;
        len_load  = 1'b0;
        left_dec  = 1'b0;
        poll_clr  = 1'b0;
        poll_inc  = 1'b0;
        pulse_clr = 1'b0;
        pulse_inc = 1'b0;
        clr_flags = 1'b0;
        set_ok    = 1'b0;
        set_ei    = 1'b0;
        set_ed    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d   = ST_PROG;
                    tmr_load  = 1'b1;
                    tmr_val   = HOLD_LD;
                    len_load  = 1'b1;
                    clr_flags = 1'b1;
                end
            end
            ST_PROG: begin
                if (tmr_zero) begin
                    state_d  = ST_WAIT_INIT;
                    poll_clr = 1'b1;
                end
            end
            ST_WAIT_INIT: begin
                if (init_s) begin
                    if (left_q == '0) begin
                        state_d   = ST_TRAIL_LO;
                        tmr_load  = 1'b1;
                        pulse_clr = 1'b1;
                    end else begin
                        state_d = ST_FETCH;
                    end
                end else if (poll_q == PW'(POLL_LIMIT - 1)) begin
                    state_d = ST_IDLE;
                    set_ei  = 1'b1;
                end else begin
                    poll_inc = 1'b1;
                end
            end
            ST_FETCH: begin
                if (byte_err_i) begin
                    state_d   = ST_TRAIL_LO;
                    tmr_load  = 1'b1;
                    pulse_clr = 1'b1;
                end else if (byte_valid_i) begin
                    state_d  = ST_BIT_LO;
                    tmr_load = 1'b1;
                    sh_load  = 1'b1;
                    left_dec = 1'b1;
                end
            end
            ST_BIT_LO: begin
                if (tmr_zero) begin
                    state_d  = ST_BIT_HI;
                    tmr_load = 1'b1;
                end
            end
            ST_BIT_HI: begin
                if (tmr_zero) begin
                    if (!sh_last) begin
                        state_d  = ST_BIT_LO;
                        tmr_load = 1'b1;
                        sh_shift = 1'b1;
                    end else if (left_q == '0) begin
                        state_d   = ST_TRAIL_LO;
                        tmr_load  = 1'b1;
                        pulse_clr = 1'b1;
                    end else begin
                        state_d = ST_FETCH;
                    end
                end
            end
            ST_TRAIL_LO: begin
                if (tmr_zero) begin
                    if (done_s) begin
                        state_d = ST_IDLE;
                        set_ok  = 1'b1;
                    end else if (pulse_q == DW'(DONE_LIMIT)) begin
                        state_d = ST_IDLE;
                        set_ed  = 1'b1;
                    end else begin
                        state_d  = ST_TRAIL_HI;
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_TRAIL_HI: begin
                if (tmr_zero) begin
                    state_d   = ST_TRAIL_LO;
                    tmr_load  = 1'b1;
                    pulse_inc = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // pin outputs
    always_comb begin
        prog_n_o     = 1'b1;
        cclk_o       = 1'b0;
        din_o        = 1'b0;
        byte_ready_o = 1'b0;
        busy_o       = 1'b1;
        unique case (state_q)
            ST_IDLE:      busy_o = 1'b0;
            ST_PROG:      prog_n_o = 1'b0;
            ST_WAIT_INIT: ;
            ST_FETCH:     byte_ready_o = 1'b1;
            ST_BIT_LO:    din_o = sh_msb;
            ST_BIT_HI: begin
                din_o  = sh_msb;
                cclk_o = 1'b1;
            end
            ST_TRAIL_LO:  ;
            ST_TRAIL_HI:  cclk_o = 1'b1;
            default:      busy_o = 1'b0;
        endcase
    end

    AST_PROG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n_o |-> (!cclk_o && !din_o)); // R2

    AST_DIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cclk_o && $past(cclk_o)) |-> (din_o == $past(din_o))); // R4

    AST_READY_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> (!cclk_o && busy_o)); // R6

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ok_o, err_init_o, err_done_o}) <= 1); // R11

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && prog_n_o && start_i) |=> prog_n_o); // R10

endmodule

// File: tb/sscfg_master_bench.sv
module sscfg_master_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int LEN_W      = 16;
    localparam int PROG_HOLD  = 5;
    localparam int HALF_PER   = 2;
    localparam int POLL_LIMIT = 40;
    localparam int DONE_LIMIT = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [LEN_W-1:0]  len_i = '0;
    logic [DATA_W-1:0] byte_data_i;
    logic              byte_valid_i = 1'b1;
    logic              byte_err_i;
    logic              byte_ready_o, prog_n_o, cclk_o, din_o;
    logic              init_i = 1'b0;
    logic              done_i = 1'b0;
    logic              busy_o, ok_o, err_init_o, err_done_o;

    sscfg_master #(
        .DATA_W(DATA_W), .LEN_W(LEN_W), .PROG_HOLD(PROG_HOLD),
        .HALF_PER(HALF_PER), .POLL_LIMIT(POLL_LIMIT), .DONE_LIMIT(DONE_LIMIT)
    ) u_sscfg_master (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .byte_data_i(byte_data_i), .byte_valid_i(byte_valid_i),
        .byte_err_i(byte_err_i), .byte_ready_o(byte_ready_o),
        .prog_n_o(prog_n_o), .cclk_o(cclk_o), .din_o(din_o),
        .init_i(init_i), .done_i(done_i), .busy_o(busy_o), .ok_o(ok_o),
        .err_init_o(err_init_o), .err_done_o(err_done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0;
    int fails = 0;

    logic [7:0] mem [0:7];
    logic [7:0] got [0:7];
    int idx = 0, err_at = -1, cap_lim = 0, done_at = 1;
    bit init_en = 1, done_en = 1, prev_cons = 0, cclk_prev = 0;
    int bi = 0, trail = 0, trail_ones = 0, prog_lo = 0, bad_prog = 0;
    int hi_run = 0, bad_hi = 0, init_ctr = 0;

    assign byte_data_i = mem[idx[2:0]];
    assign byte_err_i  = (idx == err_at);

    // target model and pin monitor
    always @(negedge clk) begin
        if (!prog_n_o) begin
            prog_lo++;
            if (cclk_o || din_o) bad_prog++;
            init_i   = 1'b0;
            init_ctr = 0;
        end else if (init_en && !init_i) begin
            init_ctr++;
            if (init_ctr >= 3) init_i = 1'b1;
        end
        if (cclk_o && !cclk_prev) begin
            if (bi < cap_lim) got[bi/8][7-(bi%8)] = din_o;
            else begin
                trail++;
                if (din_o) trail_ones++;
            end
            bi++;
        end
        if (cclk_o) hi_run++;
        else begin
            if (cclk_prev && hi_run != HALF_PER) bad_hi++;
            hi_run = 0;
        end
        cclk_prev = cclk_o;
        done_i = done_en && (trail >= done_at);
        if (prev_cons) idx++;
        prev_cons = byte_ready_o && !byte_err_i;
    end

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int len, input int e_at, input int d_at,
                       input bit i_en, input bit d_en, input int cap, input int mid_at);
        bit mid_done = 0;
        @(posedge clk);
        bi = 0; trail = 0; trail_ones = 0; prog_lo = 0; bad_prog = 0;
        bad_hi = 0; idx = 0; prev_cons = 0; hi_run = 0;
        err_at = e_at; done_at = d_at; init_en = i_en; done_en = d_en; cap_lim = cap;
        len_i = LEN_W'(len);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        while (busy_o) begin
            @(negedge clk);
            if (start_i) start_i = 1'b0;
            else if (!mid_done && mid_at > 0 && bi == mid_at) begin
                start_i  = 1'b1;
                mid_done = 1;
            end
        end
        start_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(prog_n_o == 1'b1, "R1 prog_n", prog_n_o, 1);
        chk(!cclk_o && !din_o, "R1 cclk/din", {cclk_o, din_o}, 0);
        chk(!busy_o && !byte_ready_o, "R1 busy/ready", {busy_o, byte_ready_o}, 0);
        chk({ok_o, err_init_o, err_done_o} == 3'b000, "R1 flags",
            {ok_o, err_init_o, err_done_o}, 0);
    endtask

    task automatic t_basic;
        mem[0] = 8'hA5; mem[1] = 8'h3C; mem[2] = 8'h81;
        run(3, -1, 4, 1, 1, 24, 0);
        chk(prog_lo == PROG_HOLD, "R2 prog low length", prog_lo, PROG_HOLD);
        chk(bad_prog == 0, "R2 pins quiet during prog", bad_prog, 0);
        for (int k = 0; k < 3; k++)
            chk(got[k] == mem[k], "R4 byte MSB first", got[k], mem[k]);
        chk(bad_hi == 0, "R5 clock high phase", bad_hi, 0);
        chk(idx == 3, "R6 bytes consumed", idx, 3);
        chk(trail == 4, "R7 trailing pulses", trail, 4);
        chk(trail_ones == 0, "R7 trailing din low", trail_ones, 0);
        chk(ok_o && !err_init_o && !err_done_o, "R7 ok flag", ok_o, 1);
        repeat (10) @(negedge clk);
        chk(ok_o == 1'b1, "R11 flag held while idle", ok_o, 1);
    endtask

    task automatic t_zero_len;
        run(0, -1, 2, 1, 1, 0, 0);
        chk(idx == 0, "R6 zero length consumes none", idx, 0);
        chk(trail == 2, "R6 zero length trailing", trail, 2);
        chk(ok_o == 1'b1, "R7 ok after zero length", ok_o, 1);
    endtask

    task automatic t_init_timeout;
        run(2, -1, 2, 0, 1, 16, 0);
        chk(err_init_o == 1'b1, "R3 init timeout flag", err_init_o, 1);
        chk(bi == 0, "R3 no clock without init", bi, 0);
        chk(ok_o == 1'b0, "R11 ok cleared by start", ok_o, 0);
        chk(idx == 0, "R3 no bytes consumed", idx, 0);
    endtask

    task automatic t_done_timeout;
        mem[0] = 8'h5A;
        run(1, -1, 1, 1, 0, 8, 0);
        chk(got[0] == 8'h5A, "R4 single byte", got[0], 8'h5A);
        chk(trail == DONE_LIMIT, "R8 trailing pulse limit", trail, DONE_LIMIT);
        chk(err_done_o && !ok_o, "R8 done timeout flag", err_done_o, 1);
        chk(!err_init_o, "R11 old init error cleared", err_init_o, 0);
    endtask

    task automatic t_byte_err;
        mem[0] = 8'h12; mem[1] = 8'hF0; mem[2] = 8'h77;
        run(5, 2, 3, 1, 1, 16, 0);
        chk(idx == 2, "R9 consumption stops", idx, 2);
        chk(got[0] == 8'h12 && got[1] == 8'hF0, "R9 bytes before error",
            {got[0], got[1]}, 16'h12F0);
        chk(trail == 3 && trail_ones == 0, "R9 trailing after error", trail, 3);
        chk(ok_o == 1'b1, "R9 completes with done", ok_o, 1);
    endtask

    task automatic t_busy_start;
        mem[0] = 8'h01; mem[1] = 8'h80; mem[2] = 8'hC3; mem[3] = 8'h7E;
        run(4, -1, 2, 1, 1, 32, 12);
        chk(prog_lo == PROG_HOLD, "R10 no second program pulse", prog_lo, PROG_HOLD);
        chk(idx == 4, "R10 load unchanged", idx, 4);
        for (int k = 0; k < 4; k++)
            chk(got[k] == mem[k], "R10 bytes intact", got[k], mem[k]);
        chk(ok_o == 1'b1 && trail == 2, "R10 completes", trail, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_zero_len();
        t_init_timeout();
        t_done_timeout();
        t_byte_err();
        t_busy_start();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule